// File: doc/BRIEF.md
# Dual-Mode Parallel Peripheral Port

This block sits between a processor core and an 8-bit external parallel bus. The input and output directions each have their own mode bit. In active mode the port is the bus master. A core write to a channel address emits one low pulse on the output strobe. A core read of a channel address emits one low pulse on the input strobe. The pulse width comes from the control register, and a select field tells external devices which logical channel is meant. In passive mode an external master owns the strobes. It qualifies them with an active-low chip select, and the port keeps two handshake flags for it: input buffer full and output buffer empty.

The three select pins change direction and meaning with the modes. Bit 2 is a driven channel bit only when both sides are active, and a chip-select input otherwise. Bit 1 is a driven channel bit while output is active. While output is passive it is an input that picks between the status byte and the output data on the bus. Bit 0 is always driven. It carries the channel's low bit while either side is active, and the OR of the two flags when both sides are passive. External strobes, chip select and bus data pass through a two-flop synchronizer before edge detection. The bus is a split input, output and output-enable triple so that a pad ring can build the tri-state driver.

Top module: `ppp_port`

## Requirements
- R1: After reset the control register is 0, so both sides are passive. Neither flag is set, the bus and both strobes are not driven, and the select-enable vector is 3'b001.
- R2: The port drives the bus only while the output strobe is low. In active output this is the strobe it drives itself. In passive output it is the external strobe, and only while the chip select (select bit 2) is also low.
- R3: In active output, an accepted core write to channel address 4'b0ccc drives the output strobe low for W clocks. W is control bits 7:4, with 0 treated as 1. During the pulse the bus carries the written byte and the select pins carry ccc.
- R4: In active input, a core read of channel address 4'b0ccc drives the input strobe low for W clocks with ccc on the select pins. The byte on the bus at the clock where the strobe returns high is then returned by a read of address 4'hA.
- R5: The select-enable vector is {in_active AND out_active, out_active, 1}. Control bit 0 sets input active and control bit 1 sets output active.
- R6: When both sides are passive, select bit 0 equals input-full OR output-empty.
- R7: In passive input with chip select low, the input-full flag rises exactly one clock after the synchronized rising edge of the input strobe. The captured byte is the bus value from while the strobe was still low. A core read of address 4'hA, or of a channel address, returns that byte and clears the flag.
- R8: Chip select high makes an external strobe have no effect. Setting input active clears the input-full flag.
- R9: In passive output, the output-empty flag rises exactly one clock after the synchronized rising edge of the output strobe taken with chip select low. A core channel write clears it.
- R10: In passive output with the external strobe and chip select low, select bit 1 high puts the status byte on the bus. Select bit 1 low puts the last written output byte on the bus.
- R11: A core channel access is ignored while either active strobe pulse is under way. It produces no further pulse and does not change the byte on the bus.
- R12: A read of address 4'h9 returns the status byte {4'b0, out_active, in_active, output-empty, input-full}, with input-full in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Core write request, one cycle |
| cpu_rd | input | 1 | Core read request, one cycle |
| cpu_addr | input | 4 | 0ccc channel, 8 control, 9 status, A input buffer |
| cpu_wdata | input | 8 | Core write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after cpu_rd |
| pb_in | input | 8 | Bus value seen at the pads |
| pb_out | output | 8 | Bus value driven by the port |
| pb_oe | output | 1 | Bus output enable |
| chsel_in | input | 2 | Select pins 2:1 as seen at the pads |
| chsel_out | output | 3 | Select pins driven by the port |
| chsel_oe | output | 3 | Per-pin select output enable |
| istb_in | input | 1 | External input strobe, active low |
| istb_out | output | 1 | Driven input strobe, active low |
| istb_oe | output | 1 | Input strobe output enable |
| ostb_in | input | 1 | External output strobe, active low |
| ostb_out | output | 1 | Driven output strobe, active low |
| ostb_oe | output | 1 | Output strobe output enable |

## Verification
A flag stuck or set on the wrong edge shows on select bit 0 within three clocks of a passive strobe's rising edge, since both sides are passive there. It also shows in the status byte read one cycle later. A pulse counter off by one shows as a wrong number of low cycles on the active strobe. A wrong channel register shows on the select pins during the very pulse it launches. A missing busy guard shows as an extra pulse, or as a changed bus byte, within a few clocks of a second access.

// File: rtl/ppp_pkg.sv
// Shared constants, address map and status packing for the parallel port.
// Assumes an 8-bit bus and a 4-bit pulse-width field in the control byte.
package ppp_pkg;
    localparam int DW   = 8;
    localparam int PW_W = 4;
    localparam int AW   = 4;

    localparam logic [AW-1:0] ADDR_CTRL  = 4'h8;
    localparam logic [AW-1:0] ADDR_STAT  = 4'h9;
    localparam logic [AW-1:0] ADDR_INBUF = 4'hA;

    // Control byte bit positions.
    localparam int CB_IN_ACT  = 0;
    localparam int CB_OUT_ACT = 1;
    localparam int CB_PW_LO   = 4;

    // Build the status byte: full, empty, input mode, output mode.
    function automatic logic [DW-1:0] pack_status(input logic ibf, input logic obe,
                                                  input logic in_act, input logic out_act);
        logic [DW-1:0] s;
        s    = '0;
        s[0] = ibf;
        s[1] = obe;
        s[2] = in_act;
        s[3] = out_act;
        return s;
    endfunction
endpackage

// File: rtl/ppp_sync.sv
// Two-flop synchronizer for a vector of asynchronous pad inputs.
// Assumes each bit is quasi-static compared with the clock; no bus coherency.
module ppp_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage resampling into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ppp_pulse.sv
// Active-low strobe pulse timer: start begins a pulse of max(width,1) clocks.
// Assumes start is raised only while idle; done marks the last low cycle.
module ppp_pulse #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] width,
    output logic          busy,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Load the remaining low cycles on start, count down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= (width == '0) ? '0 : width - 1'b1;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

    // R11: the owner never requests a pulse while one is running.
    p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R3: the last low cycle is followed by the strobe going high.
    p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy);
endmodule

// File: rtl/ppp_flag.sv
// Passive-mode handshake flag: sets one clock after a qualified rising edge of
// a synchronized strobe. Assumes strobe_s and cs_n_s come from ppp_sync.
module ppp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_s,
    input  logic cs_n_s,
    input  logic passive,
    input  logic clear,
    output logic rise,
    output logic flag
);
    logic strobe_q;
    logic cs_n_q;

    // Delay stage for edge detection, chip select kept aligned with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b1;
            cs_n_q   <= 1'b1;
        end else begin
            strobe_q <= strobe_s;
            cs_n_q   <= cs_n_s;
        end
    end

    assign rise = passive && strobe_s && !strobe_q && !cs_n_q;

    // Flag update: active mode clears, edge sets, core access clears.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (!passive) flag <= 1'b0;
        else if (rise)    flag <= 1'b1;
        else if (clear)   flag <= 1'b0;
    end

    // R7 (and R9 for the output instance): a set always follows an edge.
    p_flag_set_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(rise));
    // R8: an active side never holds the flag.
    p_flag_active_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !passive |=> !flag);
endmodule

// File: rtl/ppp_port.sv
// Dual-mode parallel peripheral port top. The core accesses channel, control,
// status and input-buffer addresses; the pads see split in/out/enable triples.
// Assumes single-cycle cpu_wr/cpu_rd requests and pads resolved outside.
module ppp_port
    import ppp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic          pb_oe,
    input  logic [2:1]    chsel_in,
    output logic [2:0]    chsel_out,
    output logic [2:0]    chsel_oe,
    input  logic          istb_in,
    output logic          istb_out,
    output logic          istb_oe,
    input  logic          ostb_in,
    output logic          ostb_out,
    output logic          ostb_oe
);
    localparam int SW = DW + 3;
    localparam logic [SW-1:0] SYNC_RST = {3'b111, {DW{1'b0}}};

    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] out_reg;
    logic [DW-1:0] in_reg;
    logic [DW-1:0] pb_s;
    logic [DW-1:0] pb_q;
    logic [DW-1:0] status;
    logic [2:0]    chan_q;
    logic          istb_s, ostb_s, cs_n_s;
    logic          in_act, out_act;
    logic          in_busy, in_done, out_busy, out_done;
    logic          ibf, obe, ibf_rise, obe_rise;
    logic          is_chan, wr_chan, rd_chan;
    logic          any_busy, out_start, in_start, wr_take;
    logic          ibf_clr;

    assign in_act  = ctrl_q[CB_IN_ACT];
    assign out_act = ctrl_q[CB_OUT_ACT];
    assign status  = pack_status(ibf, obe, in_act, out_act);

    // Core request decode.
    assign is_chan   = !cpu_addr[AW-1];
    assign wr_chan   = cpu_wr && is_chan;
    assign rd_chan   = cpu_rd && is_chan;
    assign any_busy  = in_busy || out_busy;
    assign out_start = wr_chan && out_act && !any_busy;
    assign in_start  = rd_chan && in_act && !any_busy;
    assign wr_take   = wr_chan && !any_busy;
    assign ibf_clr   = cpu_rd && !in_act && (is_chan || cpu_addr == ADDR_INBUF);

    ppp_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({istb_in, ostb_in, chsel_in[2], pb_in}),
        .q     ({istb_s, ostb_s, cs_n_s, pb_s})
    );

    ppp_pulse #(.CW(PW_W)) u_in_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (in_start),
        .width (ctrl_q[CB_PW_LO +: PW_W]),
        .busy  (in_busy),
        .done  (in_done)
    );

    ppp_pulse #(.CW(PW_W)) u_out_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (out_start),
        .width (ctrl_q[CB_PW_LO +: PW_W]),
        .busy  (out_busy),
        .done  (out_done)
    );

    ppp_flag u_ibf (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_s (istb_s),
        .cs_n_s   (cs_n_s),
        .passive  (!in_act),
        .clear    (ibf_clr),
        .rise     (ibf_rise),
        .flag     (ibf)
    );

    ppp_flag u_obe (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_s (ostb_s),
        .cs_n_s   (cs_n_s),
        .passive  (!out_act),
        .clear    (wr_take),
        .rise     (obe_rise),
        .flag     (obe)
    );

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ctrl_q <= '0;
        else if (cpu_wr && cpu_addr == ADDR_CTRL) ctrl_q <= cpu_wdata;
    end

    // Output data and channel latch for accepted channel accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_reg <= '0;
            chan_q  <= '0;
        end else begin
            if (wr_take)              out_reg <= cpu_wdata;
            if (out_start || in_start) chan_q <= cpu_addr[2:0];
        end
    end

    // Input capture: synchronized pipeline in passive, raw pads at pulse end in active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pb_q   <= '0;
            in_reg <= '0;
        end else begin
            pb_q <= pb_s;
            if (ibf_rise)     in_reg <= pb_q;
            else if (in_done) in_reg <= pb_in;
        end
    end

    // Registered core read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
        end else if (cpu_rd) begin
            if (is_chan || cpu_addr == ADDR_INBUF) cpu_rdata <= in_reg;
            else if (cpu_addr == ADDR_CTRL)        cpu_rdata <= ctrl_q;
            else if (cpu_addr == ADDR_STAT)        cpu_rdata <= status;
            else                                   cpu_rdata <= '0;
        end
    end

    // Pad drive: strobes, bus and mode-dependent select pins.
    always_comb begin
        istb_oe   = in_act;
        istb_out  = !in_busy;
        ostb_oe   = out_act;
        ostb_out  = !out_busy;
        pb_oe     = out_act ? out_busy : (!ostb_in && !chsel_in[2]);
        pb_out    = (!out_act && chsel_in[1]) ? status : out_reg;
        chsel_oe  = {in_act && out_act, out_act, 1'b1};
        chsel_out = {chan_q[2:1], (!in_act && !out_act) ? (ibf || obe) : chan_q[0]};
    end

    // R2: the bus is only driven while the owning output strobe is low.
    p_bus_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pb_oe |-> !(ostb_oe ? ostb_out : ostb_in));
    // R5: select bit 2 is never driven unless bit 1 is.
    p_sel_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chsel_oe[2] |-> chsel_oe[1]);
    // R11: the two strobe pulses never overlap.
    p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_busy && out_busy));
    // R3: an accepted write is followed by a low output strobe.
    p_write_pulses_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |=> (ostb_oe && !ostb_out));
    // R9: an output pulse end has no effect on the passive-only flag.
    p_obe_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> !obe_rise);
endmodule

// File: tb/ppp_port_test.sv
module ppp_port_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [2:0] ch;
        logic [7:0] d;
        int         w;
        logic [2:0] mask;
    } xfer_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [3:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [7:0] pb_in = '0;
    logic [7:0] pb_out;
    logic       pb_oe;
    logic [2:1] chsel_in = 2'b11;
    logic [2:0] chsel_out, chsel_oe;
    logic       istb_in = 1'b1, istb_out, istb_oe;
    logic       ostb_in = 1'b1, ostb_out, ostb_oe;

    int    checks = 0;
    int    failures = 0;
    int    xfers = 0;
    bit    done_flag = 0;
    xfer_t exp_q[$];

    ppp_port uut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .chsel_in(chsel_in), .chsel_out(chsel_out), .chsel_oe(chsel_oe),
        .istb_in(istb_in), .istb_out(istb_out), .istb_oe(istb_oe),
        .ostb_in(ostb_in), .ostb_out(ostb_out), .ostb_oe(ostb_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic core_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic core_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    // Driver: push the expected bus transfer, then issue the write.
    task automatic sb_write(input logic [2:0] ch, input logic [7:0] d,
                            input int w, input logic [2:0] mask);
        xfer_t it;
        it.ch = ch; it.d = d; it.w = w; it.mask = mask;
        exp_q.push_back(it);
        core_wr({1'b0, ch}, d);
    endtask

    // Monitor: measure each active output pulse and compare with the queue.
    logic [7:0] m_d;
    logic [2:0] m_s;
    logic       m_oe;
    int         m_len = 0;
    bit         m_in = 0;
    always @(negedge clk) begin
        if (rst_n && ostb_oe && !ostb_out) begin
            if (!m_in) begin
                m_in = 1; m_len = 0; m_d = pb_out; m_s = chsel_out; m_oe = pb_oe;
            end
            m_len++;
        end else if (m_in) begin
            xfer_t it;
            m_in = 0;
            xfers++;
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R11 unexpected pulse actual=0x%0h expected=none", m_d);
            end else begin
                it = exp_q.pop_front();
                chk("R3 data", m_d, it.d);
                chk("R3 width", m_len, it.w);
                chk("R3 select", m_s & it.mask, it.ch & it.mask);
                chk("R2 bus driven in pulse", m_oe, 1);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int lowc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pb_oe", pb_oe, 0);
        chk("R1 istb_oe", istb_oe, 0);
        chk("R1 ostb_oe", ostb_oe, 0);
        chk("R1 sel0 flags clear", chsel_out[0], 0);
        chk("R5 sel_oe both passive", chsel_oe, 3'b001);
        core_rd(4'h8, rd); chk("R1 control zero", rd, 0);
        core_rd(4'h9, rd); chk("R12 status at reset", rd, 0);

        // Passive output
        core_wr(4'h3, 8'hA5);
        @(negedge clk);
        chsel_in = 2'b00; ostb_in = 1'b0;
        #1 chk("R2 passive drive", pb_oe, 1);
        chk("R10 data select", pb_out, 8'hA5);
        chsel_in = 2'b01;
        #1 chk("R10 status select", pb_out, 8'h00);
        @(negedge clk);
        ostb_in = 1'b1; chsel_in = 2'b11;
        #1 chk("R2 released", pb_oe, 0);
        @(negedge clk); chk("R9 not yet (1)", chsel_out[0], 0);
        @(negedge clk); chk("R9 not yet (2)", chsel_out[0], 0);
        @(negedge clk); chk("R9 obe set, R6 sel0", chsel_out[0], 1);
        chsel_in = 2'b01; ostb_in = 1'b0;
        #1 chk("R10 status with obe", pb_out, 8'h02);
        @(negedge clk);
        ostb_in = 1'b1; chsel_in = 2'b11;
        repeat (4) @(negedge clk);
        core_wr(4'h1, 8'h3C);
        chk("R9 cleared by write", chsel_out[0], 0);
        // Chip select high: no drive, no flag
        chsel_in = 2'b10; ostb_in = 1'b0;
        #1 chk("R2 cs high no drive", pb_oe, 0);
        repeat (3) @(negedge clk);
        ostb_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 cs high no obe", chsel_out[0], 0);

        // Passive input
        pb_in = 8'h5A; chsel_in = 2'b01; istb_in = 1'b0;
        repeat (3) @(negedge clk);
        istb_in = 1'b1; pb_in = 8'hFF; chsel_in = 2'b11;
        @(negedge clk); chk("R7 not yet (1)", chsel_out[0], 0);
        @(negedge clk); chk("R7 not yet (2)", chsel_out[0], 0);
        @(negedge clk); chk("R7 ibf set, R6 sel0", chsel_out[0], 1);
        core_rd(4'h9, rd); chk("R12 status ibf", rd, 8'h01);
        core_rd(4'hA, rd); chk("R7 captured byte", rd, 8'h5A);
        chk("R7 read clears ibf", chsel_out[0], 0);
        // Chip select high input strobe
        pb_in = 8'h11; istb_in = 1'b0;
        repeat (3) @(negedge clk);
        istb_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 cs high no ibf", chsel_out[0], 0);
        // Set again, then switch input to active
        chsel_in = 2'b01; istb_in = 1'b0;
        repeat (3) @(negedge clk);
        istb_in = 1'b1; chsel_in = 2'b11;
        repeat (4) @(negedge clk);
        chk("R7 ibf set again", chsel_out[0], 1);
        core_wr(4'h8, 8'h31);
        @(negedge clk);
        core_rd(4'h9, rd); chk("R8 active clears ibf", rd, 8'h04);
        chk("R5 sel_oe input active", chsel_oe, 3'b001);

        // Active input, width 3, channel 5
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = 4'h5;
        @(negedge clk);
        cpu_rd = 1'b0; pb_in = 8'h77;
        chk("R4 strobe driven", istb_oe, 1);
        chk("R4 strobe low", istb_out, 0);
        chk("R4 select bit0", chsel_out[0], 1);
        lowc = 1;
        for (int i = 0; i < 20 && istb_out == 1'b0; i++) begin
            @(negedge clk);
            if (istb_out == 1'b0) lowc++;
        end
        chk("R4 pulse width", lowc, 3);
        pb_in = 8'h00;
        core_rd(4'hA, rd); chk("R4 captured byte", rd, 8'h77);

        // Active output, both active, width 2
        core_wr(4'h8, 8'h23);
        @(negedge clk);
        chk("R5 sel_oe both active", chsel_oe, 3'b111);
        sb_write(3'd6, 8'hC3, 2, 3'b111);
        repeat (5) @(negedge clk);
        // Output active only, width 0 means 1
        core_wr(4'h8, 8'h02);
        @(negedge clk);
        chk("R5 sel_oe output active", chsel_oe, 3'b011);
        sb_write(3'd5, 8'h99, 1, 3'b011);
        repeat (4) @(negedge clk);
        // Width 4, second write during pulse ignored
        core_wr(4'h8, 8'h42);
        sb_write(3'd1, 8'h11, 4, 3'b011);
        core_wr(4'h2, 8'h22);
        repeat (8) @(negedge clk);
        chk("R11 queue drained", exp_q.size(), 0);
        chk("R11 transfer count", xfers, 3);
        core_wr(4'h8, 8'h00);
        @(negedge clk);
        chsel_in = 2'b00; ostb_in = 1'b0;
        #1 chk("R11 ignored write kept byte", pb_out, 8'h11);
        @(negedge clk);
        ostb_in = 1'b1; chsel_in = 2'b11;
        repeat (2) @(negedge clk);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule